// File: doc/BRIEF.md
# Configurable Multi-Source I/O Port

This block is an eight-pin general-purpose I/O port for a microcontroller companion device. A per-pin multiplexer picks what each pad drives: a data-out register bit, a latched address bit, a programmable-logic macrocell output, or an external chip-select line. The multiplexer choice comes from a run-time select register, or from a static configuration mask that fixes the source for chosen pins. The pad's driver enable is the OR of a direction bit and an enable term supplied by the logic array. That term only counts on pins whose term is marked as defined; on the other pins the direction bit alone controls the driver.

On the input side, every pad passes through a two-flop synchronizer. It then enters a capture cell that runs in one of three per-pin modes: direct pass-through, transparent latch, or edge register. The cell is clocked by the address strobe or by a logic-array clock term, chosen per pin. The capture outputs drive the logic input bus. A single readback selector puts exactly one source at a time on the internal read bus: pin levels, data-out, direction, the select and mode registers, the captured values, or the macrocell outputs.

The strobe and the logic clock term are treated as levels that are synchronous to the block clock. Edges on them are detected against their value in the previous clock cycle.

Top module: `gpio_mux_port`

## Requirements
- R1: The pad output of pin i follows its select field (bits 2i+1:2i across the select bytes at offset 3 for pins 0-3 and offset 4 for pins 4-7). The encodings are 0 = data-out bit, 1 = latched address bit, 2 = macrocell output, 3 = chip-select input.
- R2: Where the static fix mask bit of pin i is 1, the static select field of pin i replaces the register field, using the same encoding.
- R3: The pad enable of pin i is 1 exactly when the direction bit is 1, or when both the logic enable term and its defined flag are 1.
- R4: A write lands in the register the offset names: 1 data-out, 2 direction (1 = drive), 3 and 4 select, 5 and 6 capture mode. The next read of that offset returns the written byte.
- R5: Reading offset 0 returns the pad input levels as they stood two clock cycles earlier.
- R6: A pin whose capture mode field (offsets 5 and 6, laid out like the select fields) is 0 or 3 puts its synchronized pin level straight onto the capture bus.
- R7: In mode 1 (latch), the capture output follows the synchronized pin level while the cell's clock source is high. While the source is low, it holds the last value taken.
- R8: In mode 2 (register), the capture output takes the synchronized pin level only on a cycle where the clock source goes from low to high. At all other times it holds.
- R9: The clock source of a capture cell is the address strobe when that pin's clock select bit is 0, and the logic clock term when it is 1.
- R10: After reset, every register reads zero. All pins are undriven, the pads carry data-out, and the capture cells run in direct mode.
- R11: Offset 7 reads the capture bus and offset 8 reads the macrocell outputs. Writes to offsets 0, 7 and 8 and above change nothing. Offsets 9 to 15 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register offset for reads and writes |
| busWrEn | input | 1 | Write strobe, sampled at the clock edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Readback of the source selected by busAddr |
| latchAddr | input | 8 | Latched address bits, one per pin |
| macroOut | input | 8 | Macrocell outputs, one per pin |
| chipSel | input | 8 | External chip-select lines, one per pin |
| logicOe | input | 8 | Logic-array enable terms |
| logicOeValid | input | 8 | Marks the pins whose enable term is defined |
| fixMask | input | 8 | Pins whose output source is fixed statically |
| fixSel | input | 16 | Static source fields, 2 bits per pin |
| clkSelect | input | 8 | Capture clock source per pin (0 strobe, 1 logic clock) |
| addrStrobe | input | 1 | Address strobe level |
| logicClk | input | 1 | Logic-array clock term level |
| padIn | input | 8 | Pad input levels |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad driver enables |
| captBus | output | 8 | Capture cell outputs to the logic input bus |

## Verification
A corrupted select or direction register shows on padOut or padOe in the same cycle the bad bit takes effect. It also shows on the next read of that offset. A wrong synchronizer stage or strobe-edge memory makes the capture bus or offset 0 disagree with the model within two cycles of an input change. A capture cell stuck in the wrong mode shows at the first strobe change. The reference model is compared on every cycle while sources, modes and strobes vary, so most faults are caught within a few cycles of the stimulus that exposes them.

// File: rtl/gmp_pkg.sv
package gmp_pkg;

  localparam int PORT_W   = 8;
  localparam int FIELD_W  = 2 * PORT_W;
  localparam int ADDR_W   = 4;

  typedef enum logic [1:0] {
    SRC_DOUT  = 2'd0,
    SRC_ADDR  = 2'd1,
    SRC_MACRO = 2'd2,
    SRC_CSEL  = 2'd3
  } srcSel_e;

  typedef enum logic [1:0] {
    CAP_DIRECT  = 2'd0,
    CAP_LATCH   = 2'd1,
    CAP_REG     = 2'd2,
    CAP_DIRECT2 = 2'd3
  } capMode_e;

  typedef enum logic [3:0] {
    RD_PIN     = 4'd0,
    RD_DOUT    = 4'd1,
    RD_DIR     = 4'd2,
    RD_CTRL_LO = 4'd3,
    RD_CTRL_HI = 4'd4,
    RD_MODE_LO = 4'd5,
    RD_MODE_HI = 4'd6,
    RD_CAPT    = 4'd7,
    RD_MACRO   = 4'd8,
    RD_NONE    = 4'd15
  } rdSel_e;

  typedef struct packed {
    logic              wrDout;
    logic              wrDir;
    logic              wrCtrlLo;
    logic              wrCtrlHi;
    logic              wrModeLo;
    logic              wrModeHi;
    logic [PORT_W-1:0] wrData;
    rdSel_e            rdSel;
  } regStrobe_t;

endpackage

// File: rtl/gmp_ctrl.sv
module gmp_ctrl
  import gmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [PORT_W-1:0] busWrData,
  output regStrobe_t        strobe
);

  always_comb begin
    strobe          = '0;
    strobe.wrData   = busWrData;
    strobe.rdSel    = RD_NONE;
    case (busAddr)
      4'd0: strobe.rdSel = RD_PIN;
      4'd1: begin
        strobe.rdSel  = RD_DOUT;
        strobe.wrDout = busWrEn;
      end
      4'd2: begin
        strobe.rdSel = RD_DIR;
        strobe.wrDir = busWrEn;
      end
      4'd3: begin
        strobe.rdSel    = RD_CTRL_LO;
        strobe.wrCtrlLo = busWrEn;
      end
      4'd4: begin
        strobe.rdSel    = RD_CTRL_HI;
        strobe.wrCtrlHi = busWrEn;
      end
      4'd5: begin
        strobe.rdSel    = RD_MODE_LO;
        strobe.wrModeLo = busWrEn;
      end
      4'd6: begin
        strobe.rdSel    = RD_MODE_HI;
        strobe.wrModeHi = busWrEn;
      end
      4'd7: strobe.rdSel = RD_CAPT;
      4'd8: strobe.rdSel = RD_MACRO;
      default: strobe.rdSel = RD_NONE;
    endcase
  end

  // R4: at most one register write strobe per cycle
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.wrDout, strobe.wrDir, strobe.wrCtrlLo,
              strobe.wrCtrlHi, strobe.wrModeLo, strobe.wrModeHi}));

  // R11: a write to a read-only or unmapped offset raises no strobe
  a_r11_ro_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && (busAddr == 4'd0 || busAddr >= 4'd7)) |->
      !(strobe.wrDout || strobe.wrDir || strobe.wrCtrlLo ||
        strobe.wrCtrlHi || strobe.wrModeLo || strobe.wrModeHi));

endmodule

// File: rtl/gmp_datapath.sv
module gmp_datapath
  import gmp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  regStrobe_t         strobe,
  input  logic [PORT_W-1:0]  latchAddr,
  input  logic [PORT_W-1:0]  macroOut,
  input  logic [PORT_W-1:0]  chipSel,
  input  logic [PORT_W-1:0]  logicOe,
  input  logic [PORT_W-1:0]  logicOeValid,
  input  logic [PORT_W-1:0]  fixMask,
  input  logic [FIELD_W-1:0] fixSel,
  input  logic [PORT_W-1:0]  clkSelect,
  input  logic               addrStrobe,
  input  logic               logicClk,
  input  logic [PORT_W-1:0]  padIn,
  output logic [PORT_W-1:0]  padOut,
  output logic [PORT_W-1:0]  padOe,
  output logic [PORT_W-1:0]  captBus,
  output logic [PORT_W-1:0]  busRdData
);

  localparam int HALF_W = FIELD_W / 2;

  logic [PORT_W-1:0]  doutReg;
  logic [PORT_W-1:0]  dirReg;
  logic [FIELD_W-1:0] ctrlReg;
  logic [FIELD_W-1:0] modeReg;
  logic [PORT_W-1:0]  syncA;
  logic [PORT_W-1:0]  syncPin;
  logic [PORT_W-1:0]  captReg;
  logic               strobePrev;
  logic               logicPrev;
  logic [PORT_W-1:0]  srcLevel;
  logic [PORT_W-1:0]  srcRise;
  logic [1:0]         warmCnt;

  // register file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doutReg <= '0;
      dirReg  <= '0;
      ctrlReg <= '0;
      modeReg <= '0;
    end else begin
      if (strobe.wrDout)   doutReg <= strobe.wrData;
      if (strobe.wrDir)    dirReg  <= strobe.wrData;
      if (strobe.wrCtrlLo) ctrlReg[HALF_W-1:0]       <= strobe.wrData;
      if (strobe.wrCtrlHi) ctrlReg[FIELD_W-1:HALF_W] <= strobe.wrData;
      if (strobe.wrModeLo) modeReg[HALF_W-1:0]       <= strobe.wrData;
      if (strobe.wrModeHi) modeReg[FIELD_W-1:HALF_W] <= strobe.wrData;
    end
  end

  // pin synchronizer and strobe history
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncA      <= '0;
      syncPin    <= '0;
      strobePrev <= 1'b0;
      logicPrev  <= 1'b0;
      warmCnt    <= '0;
    end else begin
      syncA      <= padIn;
      syncPin    <= syncA;
      strobePrev <= addrStrobe;
      logicPrev  <= logicClk;
      if (warmCnt != 2'd2) warmCnt <= warmCnt + 2'd1;
    end
  end

  // driver enable
  assign padOe = dirReg | (logicOe & logicOeValid);

  // per-pin output mux and capture cell
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    srcSel_e  pinSrc;
    capMode_e pinMode;

    assign pinSrc  = srcSel_e'(fixMask[i] ? fixSel[2*i +: 2] : ctrlReg[2*i +: 2]);
    assign pinMode = capMode_e'(modeReg[2*i +: 2]);

    always_comb begin
      case (pinSrc)
        SRC_DOUT:  padOut[i] = doutReg[i];
        SRC_ADDR:  padOut[i] = latchAddr[i];
        SRC_MACRO: padOut[i] = macroOut[i];
        default:   padOut[i] = chipSel[i];
      endcase
    end

    assign srcLevel[i] = clkSelect[i] ? logicClk : addrStrobe;
    assign srcRise[i]  = clkSelect[i] ? (logicClk & ~logicPrev)
                                      : (addrStrobe & ~strobePrev);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        captReg[i] <= 1'b0;
      end else begin
        case (pinMode)
          CAP_LATCH: if (srcLevel[i]) captReg[i] <= syncPin[i];
          CAP_REG:   if (srcRise[i])  captReg[i] <= syncPin[i];
          default:   captReg[i] <= captReg[i];
        endcase
      end
    end

    always_comb begin
      case (pinMode)
        CAP_LATCH: captBus[i] = srcLevel[i] ? syncPin[i] : captReg[i];
        CAP_REG:   captBus[i] = captReg[i];
        default:   captBus[i] = syncPin[i];
      endcase
    end

    // R7: a closed latch keeps its value
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pinMode == CAP_LATCH && !srcLevel[i]) |=> $stable(captReg[i]));

    // R8: a register cell changes only on a source rising edge
    a_r8_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pinMode == CAP_REG && !srcRise[i]) |=> $stable(captReg[i]));
  end

  // single readback selector
  always_comb begin
    case (strobe.rdSel)
      RD_PIN:     busRdData = syncPin;
      RD_DOUT:    busRdData = doutReg;
      RD_DIR:     busRdData = dirReg;
      RD_CTRL_LO: busRdData = ctrlReg[HALF_W-1:0];
      RD_CTRL_HI: busRdData = ctrlReg[FIELD_W-1:HALF_W];
      RD_MODE_LO: busRdData = modeReg[HALF_W-1:0];
      RD_MODE_HI: busRdData = modeReg[FIELD_W-1:HALF_W];
      RD_CAPT:    busRdData = captBus;
      RD_MACRO:   busRdData = macroOut;
      default:    busRdData = '0;
    endcase
  end

  // R4: a direction write is visible in the register on the next cycle
  a_r4_dir_lands: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrDir |=> dirReg == $past(strobe.wrData));

  // R11: data-out moves only when its strobe was raised
  a_r11_dout_still: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.wrDout |=> $stable(doutReg));

  // R5: pin levels reach the readback two cycles later
  a_r5_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (warmCnt == 2'd2) |-> syncPin == $past(padIn, 2));

  // R3: a pin set as output always drives
  a_r3_dir_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (dirReg & ~padOe) == '0);

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gmp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [PORT_W-1:0]  busWrData,
  output logic [PORT_W-1:0]  busRdData,
  input  logic [PORT_W-1:0]  latchAddr,
  input  logic [PORT_W-1:0]  macroOut,
  input  logic [PORT_W-1:0]  chipSel,
  input  logic [PORT_W-1:0]  logicOe,
  input  logic [PORT_W-1:0]  logicOeValid,
  input  logic [PORT_W-1:0]  fixMask,
  input  logic [FIELD_W-1:0] fixSel,
  input  logic [PORT_W-1:0]  clkSelect,
  input  logic               addrStrobe,
  input  logic               logicClk,
  input  logic [PORT_W-1:0]  padIn,
  output logic [PORT_W-1:0]  padOut,
  output logic [PORT_W-1:0]  padOe,
  output logic [PORT_W-1:0]  captBus
);

  regStrobe_t strobe;

  gmp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .strobe    (strobe)
  );

  gmp_datapath u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .latchAddr    (latchAddr),
    .macroOut     (macroOut),
    .chipSel      (chipSel),
    .logicOe      (logicOe),
    .logicOeValid (logicOeValid),
    .fixMask      (fixMask),
    .fixSel       (fixSel),
    .clkSelect    (clkSelect),
    .addrStrobe   (addrStrobe),
    .logicClk     (logicClk),
    .padIn        (padIn),
    .padOut       (padOut),
    .padOe        (padOe),
    .captBus      (captBus),
    .busRdData    (busRdData)
  );

endmodule

// File: tb/gpio_mux_port_tb.sv
`timescale 1ns/1ps
module gpio_mux_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [7:0]  latchAddr = '0, macroOut = '0, chipSel = '0;
  logic [7:0]  logicOe = '0, logicOeValid = '0, fixMask = '0, clkSelect = '0;
  logic [15:0] fixSel = '0;
  logic        addrStrobe = 1'b0, logicClk = 1'b0;
  logic [7:0]  padIn = '0;
  logic [7:0]  padOut, padOe, captBus;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_mux_port dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .latchAddr(latchAddr),
    .macroOut(macroOut), .chipSel(chipSel), .logicOe(logicOe),
    .logicOeValid(logicOeValid), .fixMask(fixMask), .fixSel(fixSel),
    .clkSelect(clkSelect), .addrStrobe(addrStrobe), .logicClk(logicClk),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .captBus(captBus)
  );

  // behavioural reference state
  int mDout, mDir, mSel [8], mMode [8], mS1 [8], mS2 [8], mCap [8];
  int mAsPrev, mLcPrev;

  always @(posedge clk) begin
    if (!rst_n) begin
      mDout = 0; mDir = 0; mAsPrev = 0; mLcPrev = 0;
      for (int i = 0; i < 8; i++) begin
        mSel[i] = 0; mMode[i] = 0; mS1[i] = 0; mS2[i] = 0; mCap[i] = 0;
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        int lvl, rise;
        lvl  = clkSelect[i] ? logicClk : addrStrobe;
        rise = clkSelect[i] ? (logicClk && mLcPrev == 0) : (addrStrobe && mAsPrev == 0);
        if (mMode[i] == 1 && lvl != 0) mCap[i] = mS2[i];
        if (mMode[i] == 2 && rise != 0) mCap[i] = mS2[i];
      end
      for (int i = 0; i < 8; i++) begin
        mS2[i] = mS1[i];
        mS1[i] = padIn[i];
      end
      mAsPrev = addrStrobe;
      mLcPrev = logicClk;
      if (busWrEn) begin
        case (busAddr)
          4'd1: mDout = busWrData;
          4'd2: mDir  = busWrData;
          4'd3: for (int i = 0; i < 4; i++) mSel[i]    = (busWrData >> (2*i)) & 3;
          4'd4: for (int i = 0; i < 4; i++) mSel[i+4]  = (busWrData >> (2*i)) & 3;
          4'd5: for (int i = 0; i < 4; i++) mMode[i]   = (busWrData >> (2*i)) & 3;
          4'd6: for (int i = 0; i < 4; i++) mMode[i+4] = (busWrData >> (2*i)) & 3;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] expOut();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      int s;
      s = fixMask[i] ? int'(fixSel[2*i +: 2]) : mSel[i];
      case (s)
        0: r[i] = mDout[i];
        1: r[i] = latchAddr[i];
        2: r[i] = macroOut[i];
        default: r[i] = chipSel[i];
      endcase
    end
    return r;
  endfunction

  function automatic logic [7:0] expCapt();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      int lvl;
      lvl = clkSelect[i] ? logicClk : addrStrobe;
      if (mMode[i] == 1)      r[i] = lvl != 0 ? mS2[i][0] : mCap[i][0];
      else if (mMode[i] == 2) r[i] = mCap[i][0];
      else                    r[i] = mS2[i][0];
    end
    return r;
  endfunction

  function automatic logic [7:0] packPairs(input int f [8], input int base);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) r[2*i +: 2] = f[base+i][1:0];
    return r;
  endfunction

  function automatic logic [7:0] expRd();
    logic [7:0] pins;
    for (int i = 0; i < 8; i++) pins[i] = mS2[i][0];
    case (busAddr)
      4'd0: return pins;
      4'd1: return mDout[7:0];
      4'd2: return mDir[7:0];
      4'd3: return packPairs(mSel, 0);
      4'd4: return packPairs(mSel, 4);
      4'd5: return packPairs(mMode, 0);
      4'd6: return packPairs(mMode, 4);
      4'd7: return expCapt();
      4'd8: return macroOut;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R1 R2 padOut", padOut, expOut());
    check("R3 padOe", padOe, mDir[7:0] | (logicOe & logicOeValid));
    check("R6 R7 R8 R9 captBus", captBus, expCapt());
    check("R4 R5 R11 busRdData", busRdData, expRd());
  endtask

  task automatic randomInputs(input int wrPct);
    busWrEn   = ($urandom_range(99) < wrPct);
    busAddr   = 4'($urandom_range(15));
    busWrData = 8'($urandom);
    latchAddr = 8'($urandom);
    macroOut  = 8'($urandom);
    chipSel   = 8'($urandom);
    logicOe   = 8'($urandom);
    if ($urandom_range(3) == 0) addrStrobe = ~addrStrobe;
    if ($urandom_range(3) == 0) logicClk   = ~logicClk;
    if ($urandom_range(2) == 0) padIn      = 8'($urandom);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    compareAll();
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    compareAll();
    busWrEn = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: every offset reads zero and no pin drives after reset
    for (int a = 0; a < 16; a++) begin
      busAddr = 4'(a);
      #0.5;
      check("R10 reset readback", busRdData, 8'h00);
    end
    check("R10 reset padOe", padOe, 8'h00);
    check("R10 reset padOut", padOut, 8'h00);
    check("R10 reset captBus", captBus, 8'h00);

    // R4: directed writes then read back
    busWrite(4'd1, 8'hA5);
    busWrite(4'd2, 8'h3C);
    busWrite(4'd3, 8'hE4);
    busWrite(4'd4, 8'h1B);
    busAddr = 4'd3; #0.5;
    check("R4 select low readback", busRdData, 8'hE4);
    // R11: writes to read-only offsets leave state unchanged
    busWrite(4'd7, 8'hFF);
    busWrite(4'd0, 8'hFF);
    busWrite(4'd9, 8'hFF);
    busAddr = 4'd1; #0.5;
    check("R11 dout after ro writes", busRdData, 8'hA5);
    busAddr = 4'd9; #0.5;
    check("R11 unmapped reads zero", busRdData, 8'h00);

    // randomized phases, each with its own static configuration
    for (int ph = 0; ph < 6; ph++) begin
      @(negedge clk);
      fixMask      = (ph >= 2) ? 8'($urandom) : 8'h00;
      fixSel       = 16'($urandom);
      logicOeValid = (ph >= 1) ? 8'($urandom) : 8'h00;
      clkSelect    = (ph >= 3) ? 8'($urandom) : 8'h00;
      busWrite(4'd5, 8'($urandom));
      busWrite(4'd6, 8'($urandom));
      for (int c = 0; c < 600; c++) begin
        @(negedge clk);
        compareAll();
        randomInputs((ph == 5) ? 40 : 10);
      end
    end
    busWrEn = 1'b0;
    repeat (3) begin
      @(negedge clk);
      compareAll();
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule